// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

The block multiplies two complex operands, X and Y, each carried as a signed real word and a signed imaginary word in fractional two's complement (Q1.15 at the default width). Four real multipliers form the partial products. Two adder/subtractors combine them into a real and an imaginary result, each a full-width Q1.31 word. The single product that cannot be represented, minus one times minus one, is clamped to the largest positive value. Two per-operand controls replace that operand with its complex conjugate, so products such as X·conj(Y) come out directly without external negation.

Each operand sits in its own input register with its own clock enable. A fixed pipeline of two register stages gives one input pair per clock and a constant fall-through of two edges. An output select picks which 16-bit slice of the two wide results drives the two output words: the upper half, the lower half, or a rounded upper half.

Top module: `cplx_mul16`

## Requirements
- R1: With `rst_n` low at a rising edge, every register clears, and after that edge both outputs read zero for every select code.
- R2: An operand pair captured at rising edge k with both enables high drives the outputs from just after edge k+1 on. A new pair may be captured at every edge.
- R3: The real result is the 32-bit two's complement sum XR·YR − XI·YI, where each product is the signed 32-bit product shifted left by one bit. The sum wraps modulo 2^32.
- R4: The imaginary result is XR·YI + XI·YR, with the same product alignment and wrap.
- R5: `conj_x` is captured together with X. When it is set, every term that contains XI changes sign, which is the same as using conj(X).
- R6: `conj_y` is captured together with Y. When it is set, every term that contains YI changes sign, which is the same as using conj(Y).
- R7: A product of the two most negative operand values (16'h8000 × 16'h8000) yields 32'h7FFF_FFFF and does not wrap to minus one.
- R8: While `ce_x` is low, the X register (XR, XI and its conjugate flag) keeps its value, whatever happens on the X inputs. `ce_y` acts the same way on the Y register.
- R9: Select codes 2'b00 and 2'b11 drive each output with bits 31:16 of its result.
- R10: Select code 2'b01 drives each output with bits 15:0 of its result.
- R11: Select code 2'b10 drives bits 31:16 plus bit 15 (round half up). When this addition would overflow past 16'h7FFF, the output is held at 16'h7FFF.
- R12: The select input acts on the outputs within the same cycle, with no clock edge, and leaves the pipeline contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| xr | input | 16 | Real part of operand X |
| xi | input | 16 | Imaginary part of operand X |
| yr | input | 16 | Real part of operand Y |
| yi | input | 16 | Imaginary part of operand Y |
| ce_x | input | 1 | Load enable for the X register |
| ce_y | input | 1 | Load enable for the Y register |
| conj_x | input | 1 | Use conj(X), captured with X |
| conj_y | input | 1 | Use conj(Y), captured with Y |
| osel | input | 2 | Output slice select |
| out_re | output | 16 | Selected slice of the real result |
| out_im | output | 16 | Selected slice of the imaginary result |

## Verification
The assertions assume that the enables, conjugate flags and data inputs are driven to known values at every rising edge after reset is released. They also assume the select input is never left undriven. The bench changes all inputs only on falling edges and holds them constant across each rising edge. It keeps every control at a defined 0 or 1 from time zero, so the register-hold and clamp properties only ever see legal operand words.

// File: rtl/cmul_pkg.sv
// Package: shared definitions for the complex multiplier.
// Assumes: select codes are fixed by the port contract of the top module.
package cmul_pkg;

    localparam int unsigned DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        SEL_UPPER = 2'b00,
        SEL_LOWER = 2'b01,
        SEL_ROUND = 2'b10,
        SEL_UPPER_ALT = 2'b11
    } osel_e;

endpackage

// File: rtl/cmul_opnd_reg.sv
// Module: one complex operand register with load enable and conjugate flag.
// Assumes: synchronous active-low reset; the enable gates real, imaginary
// and flag together so they always describe the same operand.
module cmul_opnd_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] re_d,
    input  logic [W-1:0] im_d,
    input  logic         conj_d,
    output logic [W-1:0] re_q,
    output logic [W-1:0] im_q,
    output logic         conj_q
);

    // Capture the operand when enabled, otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_q   <= '0;
            im_q   <= '0;
            conj_q <= 1'b0;
        end else if (load) begin
            re_q   <= re_d;
            im_q   <= im_d;
            conj_q <= conj_d;
        end
    end

endmodule

// File: rtl/cmul_frac_mult.sv
// Module: signed fractional multiplier, Q1.(W-1) x Q1.(W-1) -> Q1.(2W-1).
// Assumes: operands in two's complement; the redundant sign bit is removed
// by a one-bit left shift, and the most-negative squared case is clamped.
module cmul_frac_mult #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int unsigned PW = 2 * W;
    localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] MOST_POS = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] raw;
    logic                 clamp;

    // Full signed product of the two operands.
    always_comb raw = $signed(a) * $signed(b);

    // Detect the only product that leaves the fractional range.
    always_comb clamp = (a == MOST_NEG) && (b == MOST_NEG);

    // Align to fractional format, or clamp to the largest positive value.
    always_comb p = clamp ? MOST_POS : {raw[PW-2:0], 1'b0};

endmodule

// File: rtl/cmul_addsub.sv
// Module: two-input adder/subtractor with independent sign control per input.
// Assumes: result wraps modulo 2^W; negating an input is two's complement.
module cmul_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         neg_a,
    input  logic         neg_b,
    output logic [W-1:0] s
);

    logic [W-1:0] a_s;
    logic [W-1:0] b_s;

    // Apply the requested sign to each term.
    always_comb begin
        a_s = neg_a ? (~a + 1'b1) : a;
        b_s = neg_b ? (~b + 1'b1) : b;
    end

    // Sum of the signed terms.
    always_comb s = a_s + b_s;

endmodule

// File: rtl/cmul_out_sel.sv
// Module: picks a W-bit slice of a 2W-bit fractional result.
// Assumes: rounding adds the bit just below the upper half and clamps
// at the largest positive value instead of wrapping.
module cmul_out_sel
    import cmul_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [2*W-1:0] res,
    input  osel_e          sel,
    output logic [W-1:0]   dout
);

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] upper;
    logic [W-1:0] lower;
    logic [W-1:0] rounded;

    // Split the result into halves.
    always_comb begin
        upper = res[2*W-1:W];
        lower = res[W-1:0];
    end

    // Round half up with clamp at the positive limit.
    always_comb begin
        if ((upper == POS_MAX) && res[W-1])
            rounded = POS_MAX;
        else
            rounded = upper + {{(W-1){1'b0}}, res[W-1]};
    end

    // Drive the slice chosen by the select code.
    always_comb begin
        unique case (sel)
            SEL_LOWER: dout = lower;
            SEL_ROUND: dout = rounded;
            default:   dout = upper;
        endcase
    end

endmodule

// File: rtl/cplx_mul16.sv
// Module: pipelined fractional complex multiplier, top level.
// Stage 1 registers the operands, stage 2 registers the complex product.
// Assumes: synchronous active-low reset; the select input is combinational
// on the registered result.
module cplx_mul16
    import cmul_pkg::*;
#(
    parameter int unsigned W = DEF_DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] xr,
    input  logic [W-1:0] xi,
    input  logic [W-1:0] yr,
    input  logic [W-1:0] yi,
    input  logic         ce_x,
    input  logic         ce_y,
    input  logic         conj_x,
    input  logic         conj_y,
    input  logic [1:0]   osel,
    output logic [W-1:0] out_re,
    output logic [W-1:0] out_im
);

    localparam int unsigned PW = 2 * W;
    localparam int unsigned NMUL = 4;
    // product index map: 0 xr*yr, 1 xi*yi, 2 xr*yi, 3 xi*yr
    localparam int unsigned P_RR = 0;
    localparam int unsigned P_II = 1;
    localparam int unsigned P_RI = 2;
    localparam int unsigned P_IR = 3;

    logic [W-1:0]  xr_q, xi_q, yr_q, yi_q;
    logic          cjx_q, cjy_q;
    logic [W-1:0]  mul_a [NMUL];
    logic [W-1:0]  mul_b [NMUL];
    logic [PW-1:0] prod  [NMUL];
    logic [PW-1:0] sum_re, sum_im;
    logic [PW-1:0] res_re_q, res_im_q;
    logic [PW-1:0] res_q [2];
    logic [W-1:0]  dout  [2];

    cmul_opnd_reg #(.W(W)) u_xreg (
        .clk(clk), .rst_n(rst_n), .load(ce_x),
        .re_d(xr), .im_d(xi), .conj_d(conj_x),
        .re_q(xr_q), .im_q(xi_q), .conj_q(cjx_q)
    );

    cmul_opnd_reg #(.W(W)) u_yreg (
        .clk(clk), .rst_n(rst_n), .load(ce_y),
        .re_d(yr), .im_d(yi), .conj_d(conj_y),
        .re_q(yr_q), .im_q(yi_q), .conj_q(cjy_q)
    );

    // Route the operand words onto the four multipliers.
    always_comb begin
        mul_a[P_RR] = xr_q;  mul_b[P_RR] = yr_q;
        mul_a[P_II] = xi_q;  mul_b[P_II] = yi_q;
        mul_a[P_RI] = xr_q;  mul_b[P_RI] = yi_q;
        mul_a[P_IR] = xi_q;  mul_b[P_IR] = yr_q;
    end

    for (genvar m = 0; m < NMUL; m++) begin : g_mul
        cmul_frac_mult #(.W(W)) u_mul (
            .a(mul_a[m]), .b(mul_b[m]), .p(prod[m])
        );
    end

    // Real part: the imaginary-product term flips with one conjugation.
    cmul_addsub #(.W(PW)) u_add_re (
        .a(prod[P_RR]), .b(prod[P_II]),
        .neg_a(1'b0), .neg_b(~(cjx_q ^ cjy_q)),
        .s(sum_re)
    );

    // Imaginary part: each term flips with its own imaginary conjugation.
    cmul_addsub #(.W(PW)) u_add_im (
        .a(prod[P_RI]), .b(prod[P_IR]),
        .neg_a(cjy_q), .neg_b(cjx_q),
        .s(sum_im)
    );

    // Second pipeline stage holds the full-width complex result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_re_q <= '0;
            res_im_q <= '0;
        end else begin
            res_re_q <= sum_re;
            res_im_q <= sum_im;
        end
    end

    // Gather both results for the output selectors.
    always_comb begin
        res_q[0] = res_re_q;
        res_q[1] = res_im_q;
    end

    for (genvar c = 0; c < 2; c++) begin : g_osel
        cmul_out_sel #(.W(W)) u_sel (
            .res(res_q[c]), .sel(osel_e'(osel)), .dout(dout[c])
        );
    end

    // Present the selected slices.
    always_comb begin
        out_re = dout[0];
        out_im = dout[1];
    end

endmodule

// File: rtl/cplx_mul16_chk.sv
// Checker: temporal properties of the complex multiplier, bound to the top.
// Assumes: inputs are known at every rising edge after reset.
module cplx_mul16_chk #(
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ce_x,
    input logic           ce_y,
    input logic [1:0]     osel,
    input logic [W-1:0]   xr_q,
    input logic [W-1:0]   xi_q,
    input logic [W-1:0]   yr_q,
    input logic [W-1:0]   yi_q,
    input logic           cjx_q,
    input logic           cjy_q,
    input logic [2*W-1:0] res_re_q,
    input logic [2*W-1:0] res_im_q,
    input logic [W-1:0]   out_re,
    input logic [W-1:0]   out_im
);

    localparam logic [W-1:0]   MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [2*W-1:0] MOST_POS = {1'b0, {(2*W-1){1'b1}}};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out_re == '0 && out_im == '0));

    p_hold_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_x |=> ($stable(xr_q) && $stable(xi_q) && $stable(cjx_q)));

    p_hold_y_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_y |=> ($stable(yr_q) && $stable(yi_q) && $stable(cjy_q)));

    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_q == MOST_NEG && yr_q == MOST_NEG && xi_q == '0 && yi_q == '0)
        |=> (res_re_q == MOST_POS && res_im_q == '0));

    p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_q == '0 && xi_q == '0) |=> (res_re_q == '0 && res_im_q == '0));

    p_round_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (osel == 2'b10 && !res_re_q[2*W-1]) |-> !out_re[W-1]);

endmodule

bind cplx_mul16 cplx_mul16_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_x(ce_x), .ce_y(ce_y), .osel(osel),
    .xr_q(xr_q), .xi_q(xi_q), .yr_q(yr_q), .yi_q(yi_q),
    .cjx_q(cjx_q), .cjy_q(cjy_q),
    .res_re_q(res_re_q), .res_im_q(res_im_q),
    .out_re(out_re), .out_im(out_im)
);

// File: tb/cplx_mul16_tb_top.sv
// Bench: directed corners plus seeded random operands, checked against
// an independent behavioural model of the complex product.
module cplx_mul16_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] xr = '0, xi = '0, yr = '0, yi = '0;
    logic        ce_x = 1'b0, ce_y = 1'b0, conj_x = 1'b0, conj_y = 1'b0;
    logic [1:0]  osel = 2'b00;
    logic [15:0] out_re, out_im;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    cplx_mul16 dut_i (
        .clk(clk), .rst_n(rst_n), .xr(xr), .xi(xi), .yr(yr), .yi(yi),
        .ce_x(ce_x), .ce_y(ce_y), .conj_x(conj_x), .conj_y(conj_y),
        .osel(osel), .out_re(out_re), .out_im(out_im)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] fprod(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] p;
        if (a == 16'h8000 && b == 16'h8000) return 32'h7FFF_FFFF;
        p = $signed(a) * $signed(b);
        return {p[30:0], 1'b0};
    endfunction

    function automatic logic [63:0] cmodel(input logic [15:0] ar, ai, br, bi,
                                           input logic ca, cb);
        logic [31:0] t_rr, t_ii, t_ri, t_ir, re, im;
        t_rr = fprod(ar, br);
        t_ii = fprod(ai, bi);
        t_ri = fprod(ar, bi);
        t_ir = fprod(ai, br);
        re = (ca ^ cb) ? t_rr + t_ii : t_rr - t_ii;
        im = (cb ? -t_ri : t_ri) + (ca ? -t_ir : t_ir);
        return {re, im};
    endfunction

    function automatic logic [15:0] slice(input logic [31:0] r, input logic [1:0] s);
        logic [16:0] up;
        case (s)
            2'b01: return r[15:0];
            2'b10: begin
                if (r[31:16] == 16'h7FFF && r[15]) return 16'h7FFF;
                up = {1'b0, r[31:16]} + 17'(r[15]);
                return up[15:0];
            end
            default: return r[31:16];
        endcase
    endfunction

    task automatic check1(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Sweep the select code without any clock edge and check both outputs.
    task automatic check_all(input string tag, input logic [63:0] e);
        string st;
        for (int s = 0; s < 4; s++) begin
            osel = 2'(s);
            #1;
            st = (s == 1) ? "R10/R12" : (s == 2) ? "R11/R12" : "R9/R12";
            check1($sformatf("%s %s re sel=%0d", tag, st, s), out_re, slice(e[63:32], 2'(s)));
            check1($sformatf("%s %s im sel=%0d", tag, st, s), out_im, slice(e[31:0], 2'(s)));
        end
    endtask

    task automatic drive(input logic [15:0] a, b, c, d, input logic ca, cb);
        xr = a; xi = b; yr = c; yi = d; conj_x = ca; conj_y = cb;
        ce_x = 1'b1; ce_y = 1'b1;
    endtask

    // One operand pair through the full pipeline, then all slices checked.
    task automatic run_one(input string tag, input logic [15:0] a, b, c, d,
                           input logic ca, cb);
        @(negedge clk);
        drive(a, b, c, d, ca, cb);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_all(tag, cmodel(a, b, c, d, ca, cb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] sx_r [40], sx_i [40], sy_r [40], sy_i [40];
        logic        sc_x [40], sc_y [40];
        logic [63:0] e;
        void'($urandom(32'd4711));

        // R1: reset clears everything
        ce_x = 1'b1; ce_y = 1'b1;
        xr = 16'h1234; yr = 16'h4321;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ce_x = 1'b0; ce_y = 1'b0;
        check_all("R1 reset", 64'd0);

        // R3 R4 directed values
        run_one("R3 R4 quarter", 16'h4000, 16'h0000, 16'h4000, 16'h0000, 0, 0);
        run_one("R3 R4 mixed", 16'h4000, 16'h2000, 16'hC000, 16'h1000, 0, 0);
        // R7 and R11 clamp: -1*-1 -> 7FFFFFFF, rounding must not wrap
        run_one("R7 R11 clamp", 16'h8000, 16'h0000, 16'h8000, 16'h0000, 0, 0);
        run_one("R7 imag clamp", 16'h8000, 16'h8000, 16'h8000, 16'h8000, 0, 0);
        // R5 R6: -1 imaginary corners under every conjugate setting
        for (int k = 0; k < 4; k++) begin
            run_one($sformatf("R5 R6 corner conj=%0d", k),
                    16'h0000, 16'h8000, 16'h8000, 16'h8000, k[1], k[0]);
            run_one($sformatf("R5 R6 corner2 conj=%0d", k),
                    16'h7FFF, 16'h8000, 16'h0001, 16'h8000, k[1], k[0]);
        end

        // R3 R4 R5 R6 random operands with every conjugate setting
        for (int n = 0; n < 120; n++) begin
            run_one($sformatf("R3 R4 R5 R6 rand%0d", n),
                    16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                    1'(n >> 1), 1'(n));
        end

        // R2: back-to-back pairs, each appears after the second edge
        for (int i = 0; i < 40; i++) begin
            sx_r[i] = 16'($urandom); sx_i[i] = 16'($urandom);
            sy_r[i] = 16'($urandom); sy_i[i] = 16'($urandom);
            sc_x[i] = 1'($urandom);  sc_y[i] = 1'($urandom);
        end
        for (int i = 0; i < 42; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                e = cmodel(sx_r[i-2], sx_i[i-2], sy_r[i-2], sy_i[i-2], sc_x[i-2], sc_y[i-2]);
                osel = 2'($urandom);
                #1;
                check1($sformatf("R2 stream %0d re", i - 2), out_re, slice(e[63:32], osel));
                check1($sformatf("R2 stream %0d im", i - 2), out_im, slice(e[31:0], osel));
            end
            if (i < 40) drive(sx_r[i], sx_i[i], sy_r[i], sy_i[i], sc_x[i], sc_y[i]);
        end

        // R8: X held while ce_x low, including its conjugate flag
        @(negedge clk);
        drive(16'h3000, 16'hD000, 16'h1111, 16'h2222, 1, 0);
        @(posedge clk);
        @(negedge clk);
        xr = 16'h7777; xi = 16'h8000; conj_x = 1'b0; ce_x = 1'b0;
        yr = 16'h5000; yi = 16'hA000; conj_y = 1'b0; ce_y = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ce_y = 1'b0; yr = 16'h0F0F;
        @(posedge clk);
        @(negedge clk);
        check_all("R8 hold x", cmodel(16'h3000, 16'hD000, 16'h5000, 16'hA000, 1, 0));

        // R8: Y held while ce_y low
        @(negedge clk);
        drive(16'h2000, 16'h1000, 16'hE000, 16'h6000, 0, 1);
        @(posedge clk);
        @(negedge clk);
        yr = 16'h8000; yi = 16'h7FFF; conj_y = 1'b0; ce_y = 1'b0;
        xr = 16'h9000; xi = 16'h4000; conj_x = 1'b1; ce_x = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ce_x = 1'b0; xr = 16'h0001;
        @(posedge clk);
        @(negedge clk);
        check_all("R8 hold y", cmodel(16'h9000, 16'h4000, 16'hE000, 16'h6000, 1, 1));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule